// File: doc/BRIEF.md
# Guarded System Clock Source Selector

This block picks the system clock from three oscillators: a high-speed internal one, an external crystal and a low-speed internal one. Software talks to it over a small byte-wide register port. A source is turned on in the enable register. Software then polls that source's ready bit until the modelled warm-up is over, and only then writes the two-bit select field. Once the new source has taken over, software may turn the old one off. The enable and switch registers are guarded. A write to either of them lands only inside a short window that a two-byte key sequence opens.

The hardware enforces the rules itself. A write that would turn off the running source is refused as a whole. A select value that names a disabled or reserved source is stored, but the clock stays where it is and a sticky fail flag is raised. The clock itself moves through a break-before-make handover. Each source's gate is synchronised in that source's own clock domain and closes on a falling edge. The next gate opens only after every gate has been seen closed. A fourth, unguarded register holds a three-bit crystal gain level that is driven out to the oscillator.

The key logic is a state machine with three states:
- LOCKED: no key byte has been seen.
- ARMED: 0xAA was written.
- OPEN: 0x55 followed on the next cycle.

Its transitions are:
- LOCKED→ARMED on 0xAA.
- ARMED→OPEN on 0x55.
- ARMED→ARMED on a repeated 0xAA.
- ARMED→LOCKED on anything else.
- OPEN→LOCKED on an accepted guarded write or when the window runs out.

The handover logic is also a state machine with three states:
- RUN: a steady clock.
- RELEASE: all gates are requested closed.
- ACQUIRE: the target gate is requested open.

Its transitions are:
- RUN→RELEASE when the select field names an enabled, ready source other than the active one.
- RELEASE→ACQUIRE once no gate is seen on. The active source is updated at this point.
- ACQUIRE→RUN once only the new gate is seen on.

Top module: `cksw_ctrl`

## Requirements
- R1: After reset the enable register reads 0x01, the switch register reads 0x10, active_src is 0 (high-speed internal) and the fail flag is clear.
- R2: The register addresses are 0 = key, 1 = enable, 2 = switch and 3 = gain. In the enable register, bit 0 is the high-speed internal source, bit 1 the external source and bit 2 the low-speed internal source. The switch register reads as follows: bit 7 is the fail flag, bits 6:4 are the ready bits (bit 4 high-speed, bit 5 external, bit 6 low-speed), bits 2:1 are the select field, and bits 3 and 0 read 0. The select codes are 00 = high-speed internal, 01 = external, 10 = low-speed internal and 11 = reserved.
- R3: A write to the enable or switch register is accepted only in one of the 4 cycles that follow writing 0xAA and then 0x55 to the key address on consecutive cycles. Only one write is accepted per unlock. Any other such write leaves the register unchanged.
- R4: A source's ready bit sets exactly WARM cycles after the clock edge that enabled it (8, 16 and 4 cycles by default for high-speed, external and low-speed). It clears in the same cycle the source is disabled. The high-speed source is ready straight out of reset.
- R5: An accepted enable write that would clear the bit of the active source is ignored as a whole. The same holds, during a handover, for the target source. The enable register and the clock are left unchanged.
- R6: An accepted switch write whose select names a disabled source or the reserved code 11 stores the field, sets the fail flag and leaves active_src unchanged.
- R7: The fail flag stays set until an accepted switch write with bit 7 = 0 and a legal select clears it. Writing bit 7 = 1 keeps the flag.
- R8: Whenever the select field names an enabled, ready source other than the active one, the block hands over to it and active_src takes the new code. A select that waits on warm-up completes once the source becomes ready. Switching works between any pair of sources, including the two internal ones.
- R9: At most one source gate is on at any time. sys_clk runs at the rate of the active source.
- R10: The gain register resets to 0x77. Writes need no unlock and change only bits 6:4, which drive xtal_gain. Bit 7 always reads 0 and bits 3:0 always read 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| clk_hs_osc | input | 1 | High-speed internal oscillator |
| clk_ext_osc | input | 1 | External crystal clock |
| clk_ls_osc | input | 1 | Low-speed internal oscillator |
| sys_clk | output | 1 | Selected, glitch-free system clock |
| active_src | output | 2 | Code of the source now driving sys_clk |
| switch_busy | output | 1 | High while a handover is in progress |
| xtal_gain | output | 3 | Crystal gain level, 0 smallest to 7 largest |

## Verification
Several properties are checked on every cycle:
- The active source is always enabled.
- active_src changes only to a ready source.
- No two gates are ever seen on at once.
- An accepted guarded write always closes the unlock window.
- The fail flag drops only on a clearing write.
- The reserved gain bits read fixed values.

Other behaviour needs the bench's scenarios to show it:
- The exact edge of the unlock window and of warm-up.
- A refused disable.
- A fail raised on a disabled or reserved select.
- A pending select that completes after warm-up.
- The rate sys_clk actually runs at on each source.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

    localparam int NSRC = 3;
    localparam int AW   = 3;
    localparam int DW   = 8;

    // Source codes used by the select field and by enable bit positions
    localparam logic [1:0] SRC_HS  = 2'd0;
    localparam logic [1:0] SRC_EXT = 2'd1;
    localparam logic [1:0] SRC_LS  = 2'd2;
    localparam logic [1:0] SRC_RSV = 2'd3;

    localparam logic [AW-1:0] A_KEY  = 3'd0;
    localparam logic [AW-1:0] A_ENA  = 3'd1;
    localparam logic [AW-1:0] A_SWC  = 3'd2;
    localparam logic [AW-1:0] A_GAIN = 3'd3;

    localparam logic [DW-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DW-1:0] KEY_SECOND = 8'h55;

    localparam logic [2:0] GAIN_RESET = 3'b111;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'd0,
        UL_ARMED  = 2'd1,
        UL_OPEN   = 2'd2
    } ul_state_e;

    typedef enum logic [1:0] {
        SW_RUN     = 2'd0,
        SW_RELEASE = 2'd1,
        SW_ACQUIRE = 2'd2
    } sw_state_e;

    function automatic logic [NSRC-1:0] onehot3(input logic [1:0] code);
        return 3'b001 << code;
    endfunction

    // Bit of a per-source vector for a select code; the reserved code yields 0
    function automatic logic src_bit(input logic [NSRC-1:0] vec, input logic [1:0] code);
        return |(vec & onehot3(code));
    endfunction

endpackage

// File: rtl/cksw_unlock.sv
module cksw_unlock
    import cksw_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    input  logic          prot_req,
    output logic          prot_ok,
    output logic          win_open
);

    localparam int CW = $clog2(WIN_CYC + 1);

    ul_state_e      st, st_n;
    logic [CW-1:0]  cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= UL_LOCKED;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            UL_LOCKED: begin
                if (key_wr && key_data == KEY_FIRST) st_n = UL_ARMED;
            end
            UL_ARMED: begin
                if (key_wr && key_data == KEY_SECOND) begin
                    st_n  = UL_OPEN;
                    cnt_n = CW'(WIN_CYC);
                end else if (key_wr && key_data == KEY_FIRST) begin
                    st_n = UL_ARMED;
                end else begin
                    st_n = UL_LOCKED;
                end
            end
            UL_OPEN: begin
                if (prot_req || cnt == CW'(1)) st_n = UL_LOCKED;
                else                           cnt_n = cnt - CW'(1);
            end
            default: st_n = UL_LOCKED;
        endcase
    end

    always_comb begin
        win_open = (st == UL_OPEN);
        prot_ok  = prot_req && (st == UL_OPEN);
    end

endmodule

// File: rtl/cksw_warmup.sv
module cksw_warmup
    import cksw_pkg::*;
#(
    parameter int WARM_HS  = 8,
    parameter int WARM_EXT = 16,
    parameter int WARM_LS  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] ready
);

    localparam int WMAX_A = (WARM_HS > WARM_EXT) ? WARM_HS : WARM_EXT;
    localparam int WMAX   = (WMAX_A > WARM_LS) ? WMAX_A : WARM_LS;
    localparam int CW     = $clog2(WMAX + 1);

    function automatic int warm_of(input int idx);
        return (idx == 0) ? WARM_HS : ((idx == 1) ? WARM_EXT : WARM_LS);
    endfunction

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int          W     = warm_of(i);
        localparam logic [CW-1:0] WDONE = CW'(W);
        localparam logic [CW-1:0] WRST  = (i == 0) ? WDONE : '0;
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= WRST;
            else if (!en[i])         cnt <= '0;
            else if (cnt != WDONE)   cnt <= cnt + CW'(1);
        end

        assign ready[i] = en[i] && (cnt == WDONE);
    end

endmodule

// File: rtl/cksw_gfmux.sv
module cksw_gfmux
    import cksw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] gate_ack,
    output logic            sys_clk
);

    logic [NSRC-1:0] gated;

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        localparam logic RST = (i == 0);
        logic s1, s2, gate_q, a1, a2;

        // request resynchronised in the source's own domain
        always_ff @(posedge src_clk[i] or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST;
                s2 <= RST;
            end else begin
                s1 <= req[i];
                s2 <= s1;
            end
        end

        // gate changes only while the source clock is low
        always_ff @(negedge src_clk[i] or negedge rst_n) begin
            if (!rst_n) gate_q <= RST;
            else        gate_q <= s2;
        end

        // gate state reported back to the controller domain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a1 <= RST;
                a2 <= RST;
            end else begin
                a1 <= gate_q;
                a2 <= a1;
            end
        end

        assign gated[i]    = src_clk[i] & gate_q;
        assign gate_ack[i] = a2;
    end

    assign sys_clk = |gated;

endmodule

// File: rtl/cksw_ctrl.sv
module cksw_ctrl
    import cksw_pkg::*;
#(
    parameter int WIN_CYC  = 4,
    parameter int WARM_HS  = 8,
    parameter int WARM_EXT = 16,
    parameter int WARM_LS  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          clk_hs_osc,
    input  logic          clk_ext_osc,
    input  logic          clk_ls_osc,
    output logic          sys_clk,
    output logic [1:0]    active_src,
    output logic          switch_busy,
    output logic [2:0]    xtal_gain
);

    logic            key_wr, prot_req, prot_ok, win_open;
    logic            ena_acc, sw_accept, en_refuse, sel_bad;
    logic [NSRC-1:0] en_q, src_ready, gate_ack, req_q, new_en;
    logic [1:0]      sel_q, new_sel, cur_src, cur_n, tgt_src, tgt_n;
    logic            fail_q, busy_q;
    logic [2:0]      gain_q;
    sw_state_e       sw_st, sw_st_n;

    // ---------------- guarded write decode ----------------
    assign key_wr    = bus_wr && (bus_addr == A_KEY);
    assign prot_req  = bus_wr && ((bus_addr == A_ENA) || (bus_addr == A_SWC));
    assign ena_acc   = prot_ok && (bus_addr == A_ENA);
    assign sw_accept = prot_ok && (bus_addr == A_SWC);
    assign new_en    = bus_wdata[NSRC-1:0];
    assign new_sel   = bus_wdata[2:1];

    cksw_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .prot_req (prot_req),
        .prot_ok  (prot_ok),
        .win_open (win_open)
    );

    cksw_warmup #(
        .WARM_HS  (WARM_HS),
        .WARM_EXT (WARM_EXT),
        .WARM_LS  (WARM_LS)
    ) u_warmup (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .ready (src_ready)
    );

    cksw_gfmux u_gfmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_clk  ({clk_ls_osc, clk_ext_osc, clk_hs_osc}),
        .req      (req_q),
        .gate_ack (gate_ack),
        .sys_clk  (sys_clk)
    );

    // ---------------- register file ----------------
    // refuse any enable write that would drop the running source or the handover target
    assign en_refuse = !src_bit(new_en, cur_src) ||
                       ((sw_st_n != SW_RUN) && !src_bit(new_en, tgt_n));
    assign sel_bad   = (new_sel == SRC_RSV) || !src_bit(en_q, new_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= onehot3(SRC_HS);
            sel_q  <= SRC_HS;
            fail_q <= 1'b0;
            gain_q <= GAIN_RESET;
        end else begin
            if (ena_acc && !en_refuse) en_q <= new_en;
            if (sw_accept) begin
                sel_q <= new_sel;
                if (sel_bad)            fail_q <= 1'b1;
                else if (!bus_wdata[7]) fail_q <= 1'b0;
            end
            if (bus_wr && bus_addr == A_GAIN) gain_q <= bus_wdata[6:4];
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_ENA:   bus_rdata = {{(DW-NSRC){1'b0}}, en_q};
            A_SWC:   bus_rdata = {fail_q, src_ready, 1'b0, sel_q, 1'b0};
            A_GAIN:  bus_rdata = {1'b0, gain_q, 4'b0111};
            default: bus_rdata = '0;
        endcase
    end

    // ---------------- handover state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_st   <= SW_RUN;
            cur_src <= SRC_HS;
            tgt_src <= SRC_HS;
        end else begin
            sw_st   <= sw_st_n;
            cur_src <= cur_n;
            tgt_src <= tgt_n;
        end
    end

    always_comb begin
        sw_st_n = sw_st;
        cur_n   = cur_src;
        tgt_n   = tgt_src;
        unique case (sw_st)
            SW_RUN: begin
                if (sel_q != cur_src && src_bit(en_q, sel_q) && src_bit(src_ready, sel_q)) begin
                    tgt_n   = sel_q;
                    sw_st_n = SW_RELEASE;
                end
            end
            SW_RELEASE: begin
                if (gate_ack == '0) begin
                    cur_n   = tgt_src;
                    sw_st_n = SW_ACQUIRE;
                end
            end
            SW_ACQUIRE: begin
                if (gate_ack == onehot3(cur_src)) sw_st_n = SW_RUN;
            end
            default: sw_st_n = SW_RUN;
        endcase
    end

    // registered outputs: gate requests never glitch into the source domains
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= onehot3(SRC_HS);
            busy_q <= 1'b0;
        end else begin
            req_q  <= (sw_st_n == SW_RELEASE) ? '0 : onehot3(cur_n);
            busy_q <= (sw_st_n != SW_RUN);
        end
    end

    assign active_src  = cur_src;
    assign switch_busy = busy_q;
    assign xtal_gain   = gain_q;

endmodule

// File: rtl/cksw_ctrl_chk.sv
module cksw_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] en_q,
    input logic [1:0] cur_src,
    input logic [2:0] src_ready,
    input logic [2:0] gate_ack,
    input logic       fail_q,
    input logic       sw_accept,
    input logic       clr_bit,
    input logic       prot_ok,
    input logic       win_open,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_rdata
);

    AST_ACTIVE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        |(en_q & (3'b001 << cur_src))); // R5

    AST_SWITCH_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> |(src_ready & (3'b001 << cur_src))); // R8

    AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_ack)); // R9

    AST_ONE_WRITE_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        prot_ok |=> !win_open); // R3

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !(sw_accept && !clr_bit)) |=> fail_q); // R7

    AST_GAIN_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd3) |-> (bus_rdata[7] == 1'b0 && bus_rdata[3:0] == 4'b0111)); // R10

endmodule

bind cksw_ctrl cksw_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .cur_src   (cur_src),
    .src_ready (src_ready),
    .gate_ack  (gate_ack),
    .fail_q    (fail_q),
    .sw_accept (sw_accept),
    .clr_bit   (bus_wdata[7]),
    .prot_ok   (prot_ok),
    .win_open  (win_open),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/cksw_ctrl_bench.sv
`timescale 1ns/1ps
module cksw_ctrl_bench;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       osc_hs = 1'b0, osc_ext = 1'b0, osc_ls = 1'b0;
    logic       sys_clk, switch_busy;
    logic [1:0] active_src;
    logic [2:0] xtal_gain;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4  clk     = ~clk;     // 125 MHz
    always #3  osc_hs  = ~osc_hs;  // 6 ns period
    always #7  osc_ext = ~osc_ext; // 14 ns period
    always #20 osc_ls  = ~osc_ls;  // 40 ns period

    cksw_ctrl u_cksw_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .clk_hs_osc  (osc_hs),
        .clk_ext_osc (osc_ext),
        .clk_ls_osc  (osc_ls),
        .sys_clk     (sys_clk),
        .active_src  (active_src),
        .switch_busy (switch_busy),
        .xtal_gain   (xtal_gain)
    );

    // vector: {op[1:0], addr[2:0], data[7:0], expect[7:0], req[3:0]}
    // RD with addr 7 compares active_src instead of bus_rdata
    localparam logic [1:0] WR = 2'd0, RD = 2'd1, IDL = 2'd2, UNL = 2'd3;
    localparam int NV = 61;
    localparam logic [24:0] VEC [NV] = '{
        {RD,  3'd3, 8'h00, 8'h77, 4'd10},  // R10 gain reset
        {WR,  3'd3, 8'h5A, 8'h00, 4'd10},
        {RD,  3'd3, 8'h00, 8'h57, 4'd10},  // R10 only bits 6:4 change
        {WR,  3'd1, 8'h07, 8'h00, 4'd3},
        {RD,  3'd1, 8'h00, 8'h01, 4'd3},   // R3 write without key dropped
        {UNL, 3'd0, 8'h00, 8'h00, 4'd3},
        {WR,  3'd1, 8'h03, 8'h00, 4'd3},
        {RD,  3'd1, 8'h00, 8'h03, 4'd2},   // R2 enable bit positions
        {RD,  3'd2, 8'h00, 8'h10, 4'd4},   // R4 external not yet ready
        {IDL, 3'd0, 8'd20, 8'h00, 4'd4},
        {RD,  3'd2, 8'h00, 8'h30, 4'd4},   // R4 external ready
        {UNL, 3'd0, 8'h00, 8'h00, 4'd8},
        {WR,  3'd2, 8'h02, 8'h00, 4'd8},
        {IDL, 3'd0, 8'd40, 8'h00, 4'd8},
        {RD,  3'd7, 8'h00, 8'h01, 4'd8},   // R8 now on external
        {RD,  3'd2, 8'h00, 8'h32, 4'd2},   // R2 switch register layout
        {UNL, 3'd0, 8'h00, 8'h00, 4'd8},
        {WR,  3'd1, 8'h02, 8'h00, 4'd8},
        {RD,  3'd1, 8'h00, 8'h02, 4'd8},   // R8 old source may go off
        {RD,  3'd2, 8'h00, 8'h22, 4'd4},   // R4 ready clears on disable
        {UNL, 3'd0, 8'h00, 8'h00, 4'd5},
        {WR,  3'd1, 8'h01, 8'h00, 4'd5},
        {RD,  3'd1, 8'h00, 8'h02, 4'd5},   // R5 disable of active refused
        {RD,  3'd7, 8'h00, 8'h01, 4'd5},
        {UNL, 3'd0, 8'h00, 8'h00, 4'd6},
        {WR,  3'd2, 8'h04, 8'h00, 4'd6},
        {RD,  3'd2, 8'h00, 8'hA4, 4'd6},   // R6 field stored, fail set
        {IDL, 3'd0, 8'd10, 8'h00, 4'd6},
        {RD,  3'd7, 8'h00, 8'h01, 4'd6},   // R6 clock unchanged
        {WR,  3'd2, 8'h02, 8'h00, 4'd7},
        {RD,  3'd2, 8'h00, 8'hA4, 4'd7},   // R7 unguarded clear dropped
        {UNL, 3'd0, 8'h00, 8'h00, 4'd8},
        {WR,  3'd1, 8'h06, 8'h00, 4'd8},
        {IDL, 3'd0, 8'd40, 8'h00, 4'd8},
        {RD,  3'd7, 8'h00, 8'h02, 4'd8},   // R8 pending select completes
        {RD,  3'd2, 8'h00, 8'hE4, 4'd7},   // R7 fail still set
        {UNL, 3'd0, 8'h00, 8'h00, 4'd7},
        {WR,  3'd2, 8'h84, 8'h00, 4'd7},
        {RD,  3'd2, 8'h00, 8'hE4, 4'd7},   // R7 bit7=1 keeps flag
        {UNL, 3'd0, 8'h00, 8'h00, 4'd7},
        {WR,  3'd2, 8'h04, 8'h00, 4'd7},
        {RD,  3'd2, 8'h00, 8'h64, 4'd7},   // R7 flag cleared
        {UNL, 3'd0, 8'h00, 8'h00, 4'd6},
        {WR,  3'd2, 8'h06, 8'h00, 4'd6},
        {RD,  3'd2, 8'h00, 8'hE6, 4'd6},   // R6 reserved code fails
        {RD,  3'd7, 8'h00, 8'h02, 4'd6},
        {UNL, 3'd0, 8'h00, 8'h00, 4'd3},
        {IDL, 3'd0, 8'd4,  8'h00, 4'd3},
        {WR,  3'd2, 8'h04, 8'h00, 4'd3},
        {RD,  3'd2, 8'h00, 8'hE6, 4'd3},   // R3 fifth cycle is late
        {UNL, 3'd0, 8'h00, 8'h00, 4'd3},
        {IDL, 3'd0, 8'd3,  8'h00, 4'd3},
        {WR,  3'd2, 8'h04, 8'h00, 4'd3},
        {RD,  3'd2, 8'h00, 8'h64, 4'd3},   // R3 fourth cycle accepted
        {UNL, 3'd0, 8'h00, 8'h00, 4'd8},
        {WR,  3'd1, 8'h07, 8'h00, 4'd8},
        {IDL, 3'd0, 8'd20, 8'h00, 4'd8},
        {UNL, 3'd0, 8'h00, 8'h00, 4'd8},
        {WR,  3'd2, 8'h00, 8'h00, 4'd8},
        {IDL, 3'd0, 8'd40, 8'h00, 4'd8},
        {RD,  3'd7, 8'h00, 8'h00, 4'd8}    // R8 internal to internal
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic unlock();
        bus_write(3'd0, 8'hAA);
        bus_write(3'd0, 8'h55);
    endtask

    task automatic read_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic rate_check(input string req, input int exp_edges);
        int   n;
        realtime t_end;
        n = 0;
        t_end = $realtime + 1200.0;
        while ($realtime < t_end) begin
            @(posedge sys_clk);
            n++;
        end
        n_chk++;
        if (n < exp_edges - 2 || n > exp_edges + 2) begin
            n_fail++;
            $display("FAIL %s: got %0d sys_clk edges expected %0d", req, n, exp_edges);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        read_check("R1", 3'd1, 8'h01);
        read_check("R1", 3'd2, 8'h10);
        check("R1", {6'd0, active_src}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R1", 3'd2, 8'h10);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [2:0] a;
            logic [7:0] d, e;
            string      tag;
            op  = VEC[i][24:23];
            a   = VEC[i][22:20];
            d   = VEC[i][19:12];
            e   = VEC[i][11:4];
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            unique case (op)
                WR:  bus_write(a, d);
                UNL: unlock();
                IDL: begin
                    repeat (int'(d)) @(posedge clk);
                    @(negedge clk);
                end
                RD: begin
                    if (a == 3'd7) check(tag, {6'd0, active_src}, e);
                    else           read_check(tag, a, e);
                end
            endcase
        end

        // R9 rate on the high-speed source
        rate_check("R9 hs rate", 200);

        // R4 exact warm-up edge of the low-speed source
        unlock(); bus_write(3'd1, 8'h03);
        read_check("R4 ls off", 3'd2, 8'h30);
        unlock(); bus_write(3'd1, 8'h07);
        repeat (3) @(posedge clk);
        @(negedge clk);
        read_check("R4 ls warm-1", 3'd2, 8'h30);
        @(posedge clk);
        @(negedge clk);
        read_check("R4 ls warm", 3'd2, 8'h70);

        // R8 / R9 switch to low-speed and measure its rate
        unlock(); bus_write(3'd2, 8'h04);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R8 on ls", {6'd0, active_src}, 8'h02);
        check("R8 idle", {7'd0, switch_busy}, 8'h00);
        rate_check("R9 ls rate", 30);

        // R1 / R10 reset mid-operation
        bus_write(3'd3, 8'h10);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        read_check("R1 after reset", 3'd1, 8'h01);
        read_check("R1 after reset", 3'd2, 8'h10);
        check("R1 active", {6'd0, active_src}, 8'h00);
        read_check("R10 gain reset", 3'd3, 8'h77);
        check("R10 gain pins", {5'd0, xtal_gain}, 8'h07);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rate_check("R9 hs after reset", 200);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule